// File: doc/BRIEF.md
# Security-Banked Fault Status Register Slice

This block holds the fault status word and the bus fault address register for a processor core that runs in a secure state and a non-secure state. Software reaches the registers through a request/response port. Every request carries a secure attribute, a byte offset, an access size and an optional write value. Fault logic elsewhere in the core records new faults through plain set inputs and an address capture input.

Most status fields have one copy per security state. The bus-fault byte, bits [15:8], has only one copy, which both states share. The input `ns_bf_allow` controls whether non-secure software can see bus-fault information. When it is low, a non-secure access finds the shared byte and the fault address register reading as zero, and its writes to them have no effect.

The request channel follows valid/ready rules. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears one cycle later and is held until the edge where `rsp_ready` is high. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so a new request is stalled rather than lost. A requester must hold its request fields stable while `req_valid` is high and `req_ready` is low.

Top module: `fsr_banked_regs`

## Requirements
- R1: After reset both status copies and the fault address register are zero, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read of the status word returns the requester's own copy, with bits [15:8] taken from the shared copy. The secure copy holds no bits of its own in [15:8].
- R3: The size field selects the access width: 0 is a byte, 1 is a half word, 2 is a word, and 3 is reserved and gives an error. The lane is the offset minus STAT_OFS (default 0xd28). Read data is returned right-justified. An access with lane plus byte count greater than 4 gives an error.
- R4: A status write clears, in the requester's copy, each bit that is written as one. A secure write that has ones in bits [15:8] clears those bits in the shared copy.
- R5: While `ns_bf_allow` is 0, a non-secure status read returns zero in bits [15:8], and a non-secure status write leaves bits [15:8] unchanged.
- R6: The fault address register sits at ADDR_OFS (default 0xd38) and accepts word-size accesses only; other sizes give an error. While `ns_bf_allow` is 0, a non-secure read returns zero and a non-secure write is ignored. In every other case it reads and writes normally.
- R7: When `set_valid` is high, bits [15:8] of `set_bits` are ORed into the shared copy and the other bits are ORed into the copy that `set_secure` selects. If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: When `hw_addr_valid` is high, the fault address register loads `hw_addr`. This load wins over a bus write in the same cycle.
- R9: With HAS_MAINLINE=0, every access gives an error with zero data.
- R10: An access to any other offset gives an error and changes no state. Error responses and write responses carry zero data.
- R11: A response appears in the cycle after its request is accepted. Its data and error flag are held while `rsp_ready` is low. While a response is waiting and `rsp_ready` is low, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ns_bf_allow | input | 1 | Non-secure software may see bus-fault state |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Requester is in the secure state |
| req_offset | input | OFS_W | Byte offset |
| req_size | input | 2 | 0 = byte, 1 = half word, 2 = word, 3 = reserved |
| req_wdata | input | DATA_W | Write data, right-justified |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | DATA_W | Read data, right-justified |
| set_valid | input | 1 | Hardware fault status set strobe |
| set_secure | input | 1 | Copy that receives the banked set bits |
| set_bits | input | DATA_W | Status bits to set |
| hw_addr_valid | input | 1 | Capture a bus fault address |
| hw_addr | input | DATA_W | Fault address to capture |

## Verification
The bench builds the block twice. `u_dut` uses the defaults: HAS_MAINLINE=1, the status word at 0xd28 and the fault address register at 0xd38. `u_dut_nomain` uses HAS_MAINLINE=0, so the error-only decode variant runs on the same request stream. Offsets 0xd24, 0xd2c, 0xd30 and 0xd3c fall just outside the mapped window. Combined with half-word and word sizes at the upper lanes, they exercise both the unmapped-offset error and the lane-overflow error. Toggling `ns_bf_allow` across random secure and non-secure traffic, with coincident hardware sets and address captures, exercises the hiding of the shared byte and the set-over-clear priority.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_STAT = 2'd1,
    TGT_ADDR = 2'd2
  } target_e;

  localparam int BF_LSB = 8;
  localparam int BF_WIDTH = 8;
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
  import fsr_pkg::*;
#(
  parameter bit HAS_MAINLINE = 1'b1,
  parameter int OFS_W = 12,
  parameter int NB = 4,
  parameter int LANE_W = 2,
  parameter logic [OFS_W-1:0] STAT_OFS = 'hd28,
  parameter logic [OFS_W-1:0] ADDR_OFS = 'hd38
) (
  input  logic [OFS_W-1:0]  offset,
  input  logic [1:0]        size,
  output target_e           tgt,
  output logic              err,
  output logic [LANE_W-1:0] lane,
  output logic [NB-1:0]     byte_en
);
  generate
    if (HAS_MAINLINE) begin : g_main
      logic [OFS_W-1:0]  diff;
      logic [LANE_W+1:0] nbytes;
      logic [LANE_W+1:0] end_pos;
      logic              stat_ok;
      logic              addr_ok;

      always_comb begin
        diff    = offset - STAT_OFS;
        lane    = diff[LANE_W-1:0];
        nbytes  = (LANE_W+2)'(1) << size;
        end_pos = (LANE_W+2)'(lane) + nbytes;
        stat_ok = (diff < OFS_W'(NB)) && (size != SZ_RSVD) &&
                  (end_pos <= (LANE_W+2)'(NB));
        addr_ok = (offset == ADDR_OFS) && (size == SZ_WORD);
        tgt     = stat_ok ? TGT_STAT : (addr_ok ? TGT_ADDR : TGT_NONE);
        err     = !(stat_ok || addr_ok);
        for (int i = 0; i < NB; i++) begin
          byte_en[i] = stat_ok && ((LANE_W+2)'(i) >= (LANE_W+2)'(lane)) &&
                       ((LANE_W+2)'(i) < end_pos);
        end
      end
    end else begin : g_nomain
      always_comb begin
        tgt     = TGT_NONE;
        err     = 1'b1;
        lane    = '0;
        byte_en = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/fsr_status_bank.sv
module fsr_status_bank
  import fsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_secure,
  input  logic              rd_hide,
  output logic [DATA_W-1:0] rd_word,
  input  logic              clr_en,
  input  logic              clr_secure,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic              set_valid,
  input  logic              set_secure,
  input  logic [DATA_W-1:0] set_bits
);
  localparam logic [DATA_W-1:0] BF_MASK =
    DATA_W'({BF_WIDTH{1'b1}}) << BF_LSB;

  logic [DATA_W-1:0] stat_s_q, stat_ns_q;
  logic [DATA_W-1:0] clr_s, clr_ns, set_s, set_ns;

  always_comb begin
    clr_s  = '0;
    clr_ns = '0;
    if (clr_en) begin
      if (clr_secure) begin
        clr_s  = clr_bits & ~BF_MASK;
        clr_ns = clr_bits & BF_MASK;
      end else begin
        clr_ns = clr_bits;
      end
    end
    set_s  = '0;
    set_ns = '0;
    if (set_valid) begin
      set_ns = set_bits & BF_MASK;
      if (set_secure) set_s  = set_bits & ~BF_MASK;
      else            set_ns = set_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_s_q  <= '0;
      stat_ns_q <= '0;
    end else begin
      stat_s_q  <= (stat_s_q & ~clr_s) | set_s;
      stat_ns_q <= (stat_ns_q & ~clr_ns) | set_ns;
    end
  end

  always_comb begin
    rd_word = ((rd_secure ? stat_s_q : stat_ns_q) & ~BF_MASK) |
              (rd_hide ? '0 : (stat_ns_q & BF_MASK));
  end
endmodule

// File: rtl/fsr_addr_reg.sv
module fsr_addr_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              hw_we,
  input  logic [DATA_W-1:0] hw_wdata,
  output logic [DATA_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (hw_we)  value <= hw_wdata;
    else if (bus_we) value <= bus_wdata;
  end
endmodule

// File: rtl/fsr_rsp_slot.sv
module fsr_rsp_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              in_err,
  input  logic [DATA_W-1:0] in_data,
  output logic              free,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= in_err;
      rsp_rdata <= in_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fsr_banked_regs.sv
module fsr_banked_regs
  import fsr_pkg::*;
#(
  parameter bit HAS_MAINLINE = 1'b1,
  parameter int OFS_W = 12,
  parameter int DATA_W = 32,
  parameter logic [OFS_W-1:0] STAT_OFS = 'hd28,
  parameter logic [OFS_W-1:0] ADDR_OFS = 'hd38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ns_bf_allow,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              set_valid,
  input  logic              set_secure,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              hw_addr_valid,
  input  logic [DATA_W-1:0] hw_addr
);
  localparam int NB = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);
  localparam logic [DATA_W-1:0] BF_MASK =
    DATA_W'({BF_WIDTH{1'b1}}) << BF_LSB;

  target_e           tgt;
  logic              dec_err;
  logic [LANE_W-1:0] lane;
  logic [NB-1:0]     byte_en;
  logic [DATA_W-1:0] bit_en;
  logic              accept, hide;
  logic [DATA_W-1:0] stat_word, addr_value, clr_bits, rsp_data;
  logic              clr_en, addr_we;

  fsr_decode #(
    .HAS_MAINLINE(HAS_MAINLINE), .OFS_W(OFS_W), .NB(NB), .LANE_W(LANE_W),
    .STAT_OFS(STAT_OFS), .ADDR_OFS(ADDR_OFS)
  ) u_decode (
    .offset(req_offset), .size(req_size), .tgt(tgt), .err(dec_err),
    .lane(lane), .byte_en(byte_en)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bit_en
    assign bit_en[8*b +: 8] = {8{byte_en[b]}};
  end

  assign accept = req_valid && req_ready;
  assign hide   = !req_secure && !ns_bf_allow;

  always_comb begin
    clr_bits = (req_wdata << {lane, 3'b000}) & bit_en;
    if (hide) clr_bits = clr_bits & ~BF_MASK;
    clr_en  = accept && req_write && (tgt == TGT_STAT);
    addr_we = accept && req_write && (tgt == TGT_ADDR) && !hide;
  end

  fsr_status_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_secure(req_secure), .rd_hide(hide), .rd_word(stat_word),
    .clr_en(clr_en), .clr_secure(req_secure), .clr_bits(clr_bits),
    .set_valid(set_valid), .set_secure(set_secure), .set_bits(set_bits)
  );

  fsr_addr_reg #(.DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .bus_we(addr_we), .bus_wdata(req_wdata),
    .hw_we(hw_addr_valid), .hw_wdata(hw_addr), .value(addr_value)
  );

  always_comb begin
    rsp_data = '0;
    if (!dec_err && !req_write) begin
      if (tgt == TGT_STAT) rsp_data = (stat_word & bit_en) >> {lane, 3'b000};
      else if (!hide)      rsp_data = addr_value;
    end
  end

  fsr_rsp_slot #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_err(dec_err),
    .in_data(rsp_data), .free(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/fsr_banked_regs_chk.sv
module fsr_banked_regs_chk #(
  parameter bit HAS_MAINLINE = 1'b1,
  parameter int OFS_W = 12,
  parameter int DATA_W = 32,
  parameter logic [OFS_W-1:0] STAT_OFS = 'hd28,
  parameter logic [OFS_W-1:0] ADDR_OFS = 'hd38
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ns_bf_allow,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_secure,
  input logic [OFS_W-1:0]  req_offset,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata
);
  logic acc;
  logic ns_hidden_rd;
  assign acc = req_valid && req_ready;
  assign ns_hidden_rd = acc && !req_write && !req_secure && !ns_bf_allow &&
                        (req_size == 2'd2);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R11

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !acc) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R11

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R10

  AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (rsp_rdata == '0)); // R10

  AST_NS_BF_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_hidden_rd && req_offset == STAT_OFS) |=> (rsp_rdata[15:8] == 8'h00)); // R5

  AST_NS_ADDR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_hidden_rd && req_offset == ADDR_OFS) |=> (rsp_rdata == '0)); // R6

  AST_NOMAIN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !HAS_MAINLINE) |=> rsp_err); // R9
endmodule

bind fsr_banked_regs fsr_banked_regs_chk #(
  .HAS_MAINLINE(HAS_MAINLINE), .OFS_W(OFS_W), .DATA_W(DATA_W),
  .STAT_OFS(STAT_OFS), .ADDR_OFS(ADDR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ns_bf_allow(ns_bf_allow),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_secure(req_secure), .req_offset(req_offset), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata)
);

// File: tb/fsr_banked_regs_tb.sv
`timescale 1ns/1ps
module fsr_banked_regs_tb;
  localparam logic [31:0] BF = 32'h0000_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ns_bf_allow = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        set_valid = 1'b0, set_secure = 1'b0;
  logic [31:0] set_bits = '0;
  logic        hw_addr_valid = 1'b0;
  logic [31:0] hw_addr = '0;

  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        nm_req_ready, nm_rsp_valid, nm_rsp_err;
  logic [31:0] nm_rsp_rdata;

  always #2.5 clk = ~clk;

  fsr_banked_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ns_bf_allow(ns_bf_allow),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_secure(req_secure), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .set_valid(set_valid),
    .set_secure(set_secure), .set_bits(set_bits),
    .hw_addr_valid(hw_addr_valid), .hw_addr(hw_addr)
  );

  fsr_banked_regs #(.HAS_MAINLINE(1'b0)) u_dut_nomain (
    .clk(clk), .rst_n(rst_n), .ns_bf_allow(ns_bf_allow),
    .req_valid(req_valid), .req_ready(nm_req_ready), .req_write(req_write),
    .req_secure(req_secure), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(nm_rsp_valid), .rsp_ready(rsp_ready),
    .rsp_err(nm_rsp_err), .rsp_rdata(nm_rsp_rdata), .set_valid(set_valid),
    .set_secure(set_secure), .set_bits(set_bits),
    .hw_addr_valid(hw_addr_valid), .hw_addr(hw_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_s = '0, m_ns = '0, m_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input logic [11:0] ofs, input logic [1:0] sz);
    int lane;
    if (ofs >= 12'hd28 && ofs <= 12'hd2b) begin
      lane = int'(ofs - 12'hd28);
      return (sz == 2'd3) || (lane + (1 << sz) > 4);
    end
    if (ofs == 12'hd38) return sz != 2'd2;
    return 1'b1;
  endfunction

  function automatic logic [31:0] stat_view(input bit sec);
    logic [31:0] base;
    base = sec ? m_s : m_ns;
    return (base & ~BF) | ((!sec && !ns_bf_allow) ? 32'h0 : (m_ns & BF));
  endfunction

  function automatic logic [31:0] byte_bits(input int lane, input logic [1:0] sz);
    logic [63:0] m;
    m = ((64'd1 << (8 * (1 << sz))) - 64'd1) << (8 * lane);
    return m[31:0];
  endfunction

  function automatic logic [31:0] exp_data(input bit sec, input bit wr,
                                           input logic [11:0] ofs,
                                           input logic [1:0] sz);
    int lane;
    if (wr || exp_err(ofs, sz)) return 32'h0;
    if (ofs == 12'hd38) return (!sec && !ns_bf_allow) ? 32'h0 : m_addr;
    lane = int'(ofs - 12'hd28);
    return (stat_view(sec) & byte_bits(lane, sz)) >> (8 * lane);
  endfunction

  // Caller is at a negative edge; any set/hw_addr strobes already driven
  // apply in the same cycle as the request.
  task automatic access(input bit sec, input bit wr, input logic [11:0] ofs,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input string tag);
    bit e;
    logic [31:0] d, v;
    int lane;
    e = exp_err(ofs, sz);
    d = exp_data(sec, wr, ofs, sz);
    req_valid = 1'b1; req_write = wr; req_secure = sec;
    req_offset = ofs; req_size = sz; req_wdata = wd;
    @(posedge clk);
    if (wr && !e && ofs != 12'hd38) begin
      lane = int'(ofs - 12'hd28);
      v = (wd << (8 * lane)) & byte_bits(lane, sz);
      if (!sec && !ns_bf_allow) v = v & ~BF;
      if (sec) begin
        m_s  = m_s & ~(v & ~BF);
        m_ns = m_ns & ~(v & BF);
      end else begin
        m_ns = m_ns & ~v;
      end
    end
    if (wr && !e && ofs == 12'hd38 && !(!sec && !ns_bf_allow)) m_addr = wd;
    if (set_valid) begin
      m_ns = m_ns | (set_bits & BF);
      if (set_secure) m_s  = m_s | (set_bits & ~BF);
      else            m_ns = m_ns | (set_bits & ~BF);
    end
    if (hw_addr_valid) m_addr = hw_addr;
    @(negedge clk);
    req_valid = 1'b0; set_valid = 1'b0; hw_addr_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R11 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    chk(rsp_err == e, {tag, " err"}, {31'b0, rsp_err}, {31'b0, e});
    chk(rsp_rdata == d, {tag, " data"}, rsp_rdata, d);
    chk(nm_rsp_err == 1'b1 && nm_rsp_rdata == 32'h0, "R9 nomain error",
        nm_rsp_rdata, 32'h0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
    end
  end

  initial begin
    logic [11:0] ofs_pool [8];
    void'($urandom(32'd1234));
    ofs_pool[0] = 12'hd28; ofs_pool[1] = 12'hd29; ofs_pool[2] = 12'hd2a;
    ofs_pool[3] = 12'hd2b; ofs_pool[4] = 12'hd38; ofs_pool[5] = 12'hd2c;
    ofs_pool[6] = 12'hd24; ofs_pool[7] = 12'hd3c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 idle after reset",
        {30'b0, req_ready, rsp_valid}, 32'h2);
    access(1'b1, 1'b0, 12'hd28, 2'd2, 32'h0, "R1 secure status");
    access(1'b0, 1'b0, 12'hd28, 2'd2, 32'h0, "R1 nonsecure status");
    access(1'b1, 1'b0, 12'hd38, 2'd2, 32'h0, "R1 address");

    set_valid = 1'b1; set_secure = 1'b1; set_bits = 32'h00FF_FF03;
    access(1'b1, 1'b0, 12'hd30, 2'd2, 32'h0, "R10 unmapped");
    access(1'b1, 1'b0, 12'hd28, 2'd2, 32'h0, "R2 secure merged");
    chk(rsp_rdata == 32'h00FF_FF03, "R7 banked set", rsp_rdata, 32'h00FF_FF03);
    access(1'b0, 1'b0, 12'hd28, 2'd2, 32'h0, "R2 nonsecure shared byte");
    chk(rsp_rdata == 32'h0000_FF00, "R2 shared copy", rsp_rdata, 32'h0000_FF00);
    set_valid = 1'b1; set_secure = 1'b0; set_bits = 32'h0000_0012;
    access(1'b0, 1'b1, 12'hd31, 2'd2, 32'hFFFF_FFFF, "R10 unmapped write");
    access(1'b0, 1'b0, 12'hd29, 2'd0, 32'h0, "R3 byte lane 1");
    access(1'b1, 1'b0, 12'hd2a, 2'd1, 32'h0, "R3 half lane 2");
    access(1'b1, 1'b0, 12'hd2b, 2'd1, 32'h0, "R3 lane overflow");
    access(1'b1, 1'b0, 12'hd28, 2'd3, 32'h0, "R3 reserved size");

    ns_bf_allow = 1'b0;
    access(1'b0, 1'b0, 12'hd28, 2'd2, 32'h0, "R5 hidden read");
    chk(rsp_rdata == 32'h0000_0012, "R5 hidden value", rsp_rdata, 32'h12);
    access(1'b0, 1'b1, 12'hd28, 2'd2, 32'hFFFF_FFFF, "R5 hidden write");
    access(1'b1, 1'b0, 12'hd28, 2'd2, 32'h0, "R5 shared byte kept");
    access(1'b1, 1'b1, 12'hd29, 2'd0, 32'h0F, "R4 secure clears shared");
    ns_bf_allow = 1'b1;
    access(1'b0, 1'b0, 12'hd28, 2'd2, 32'h0, "R4 shared after clear");
    chk(rsp_rdata == 32'h0000_F000, "R4 shared value", rsp_rdata, 32'hF000);
    set_valid = 1'b1; set_secure = 1'b0; set_bits = 32'h0000_0100;
    access(1'b0, 1'b1, 12'hd28, 2'd2, 32'h0000_0100, "R7 set beats clear");
    access(1'b0, 1'b0, 12'hd29, 2'd0, 32'h0, "R7 after race");
    chk(rsp_rdata == 32'h0000_00F1, "R7 bit kept", rsp_rdata, 32'hF1);

    access(1'b1, 1'b1, 12'hd38, 2'd2, 32'hDEAD_BEEF, "R6 secure write");
    ns_bf_allow = 1'b0;
    access(1'b0, 1'b0, 12'hd38, 2'd2, 32'h0, "R6 hidden read");
    access(1'b0, 1'b1, 12'hd38, 2'd2, 32'h0000_1234, "R6 hidden write");
    access(1'b1, 1'b0, 12'hd38, 2'd2, 32'h0, "R6 value kept");
    chk(rsp_rdata == 32'hDEAD_BEEF, "R6 kept value", rsp_rdata, 32'hDEAD_BEEF);
    access(1'b1, 1'b0, 12'hd38, 2'd0, 32'h0, "R6 byte size error");
    hw_addr_valid = 1'b1; hw_addr = 32'h2000_0040;
    access(1'b1, 1'b1, 12'hd38, 2'd2, 32'h1111_1111, "R8 capture race");
    access(1'b1, 1'b0, 12'hd38, 2'd2, 32'h0, "R8 capture wins");
    chk(rsp_rdata == 32'h2000_0040, "R8 captured", rsp_rdata, 32'h2000_0040);

    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_secure = 1'b1;
    req_offset = 12'hd38; req_size = 2'd2;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !req_ready, "R11 stall", {30'b0, rsp_valid, req_ready},
        32'h2);
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_rdata == m_addr, "R11 held data", rsp_rdata, m_addr);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R11 drained", {30'b0, rsp_valid, req_ready},
        32'h1);

    for (int i = 0; i < 600; i++) begin
      logic [11:0] o;
      bit w, s;
      string tag;
      o = ofs_pool[$urandom_range(0, 7)];
      w = 1'($urandom_range(0, 1));
      s = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) ns_bf_allow = ~ns_bf_allow;
      if ($urandom_range(0, 3) == 0) begin
        set_valid = 1'b1; set_secure = 1'($urandom_range(0, 1));
        set_bits = $urandom() & $urandom();
      end
      if ($urandom_range(0, 9) == 0) begin
        hw_addr_valid = 1'b1; hw_addr = $urandom();
      end
      tag = (o == 12'hd38) ? "R6 random" :
            ((o >= 12'hd28 && o <= 12'hd2b) ? "R2 random" : "R10 random");
      access(s, w, o, 2'($urandom_range(0, 3)), $urandom(), tag);
    end

    done = 1'b1;
    finish_run();
  end
endmodule